// File: doc/BRIEF.md
# Double-Buffered Indexed Colour Palette

This block turns 8-bit pixel indices into 24-bit RGB colours through a 256-entry lookup table that exists twice. One copy, the live bank, serves the display path; the other, the shadow bank, is open to the processor through a small word-addressed register port. Software loads a complete new palette into the shadow bank. It then flips a request bit in the control word. The two banks trade roles at the next frame-start pulse, so a frame is never coloured from a partly rewritten table.

The control word holds two bits. Bit 0 is the request, which software writes. Bit 1 is the live-bank flag, which software can only read. While the two bits differ a swap is waiting; once they match again the shadow bank is free to be rewritten. Lookups take effect only when the pixel format selects indexed colour. In every other format the lookup output stays dark.

Top module: `palette_dbuf`

## Requirements
- R1: After reset the request bit and the live-bank flag are 0 (bank 0 live), `rgb_valid` is 0, `rgb_out` is 0 and `cpu_rdata` is 0.
- R2: Palette entry n sits at byte offset 4·n (offsets 0x000 to 0x3FC). A stored word keeps blue in bits 7:0, green in 15:8 and red in 23:16. Written bits 31:24 are dropped and read back as 0.
- R3: A processor write to a palette offset always lands in the shadow bank (the bank whose index differs from the live-bank flag). It never changes the colours returned by lookups.
- R4: A read strobe on a palette offset returns that shadow-bank entry on `cpu_rdata` one cycle later. In any cycle that follows a cycle without a read strobe, `cpu_rdata` is 0.
- R5: The control word sits at byte offset 0x400. A read returns the request in bit 0, the live-bank flag in bit 1 and zeros above. A write sets the request from write bit 0; write bit 1 and all higher bits have no effect.
- R6: The live-bank flag changes only on a cycle with `frame_start` high, and then takes the value the request held in that cycle. A swap is therefore pending exactly while request and flag differ.
- R7: When `pix_valid` is high and the pixel format is indexed (`pix_mode` = 2 and `col_mode` = 0), the next cycle shows `rgb_valid` = 1 and `rgb_out` = the live-bank entry at `pix_index`. The live bank is judged as it was in the cycle of the index.
- R8: In a cycle after a cycle with `pix_valid` low or with any other pixel format, `rgb_valid` is 0 and `rgb_out` is 0.
- R9: Toggling the request and toggling it back before any frame-start pulse leaves no swap pending; the next pulse keeps the same live bank.
- R10: Offsets from 0x404 to 0x7FC are unmapped. Writes there change no palette entry and no control bit, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 11 | Byte offset of the register access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, one cycle after `cpu_rd` |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| pix_valid | input | 1 | Pixel index valid |
| pix_index | input | 8 | Pixel colour index |
| pix_mode | input | 3 | Pixel depth field (2 = indexed 8-bit) |
| col_mode | input | 3 | Colour format field (0 = lookup) |
| rgb_valid | output | 1 | Lookup result valid |
| rgb_out | output | 24 | Looked-up colour, red in 23:16 |

## Verification
Every result of this block is due exactly one clock after the cycle that causes it. Lookup colours and register read data follow their strobe by one cycle. A request write or a frame-start pulse is seen by accesses from the following cycle on, while lookups and reads in the pulse cycle still use the old live bank. The bench drives inputs on the falling edge and updates a behavioural model of both banks and both control bits on the rising edge. It then compares `rgb_valid`, `rgb_out` and `cpu_rdata` with the model on the next falling edge, so each comparison sits one register stage behind its stimulus.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int CH_W    = 8;
  localparam int ENTRY_W = 3 * CH_W;
  localparam int WORD_W  = 32;
  localparam int MODE_W  = 3;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
  } rgb_t;

  function automatic rgb_t bits_to_rgb(input logic [ENTRY_W-1:0] b);
    rgb_t c;
    c.red   = b[3*CH_W-1:2*CH_W];
    c.green = b[2*CH_W-1:CH_W];
    c.blue  = b[CH_W-1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] rgb_to_word(input rgb_t c);
    return {{(WORD_W-ENTRY_W){1'b0}}, c.red, c.green, c.blue};
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_word(input logic live, input logic req);
    return {{(WORD_W-2){1'b0}}, live, req};
  endfunction

  function automatic logic is_index_fmt(input logic [MODE_W-1:0] pm,
                                        input logic [MODE_W-1:0] cm,
                                        input logic [MODE_W-1:0] want_pm,
                                        input logic [MODE_W-1:0] want_cm);
    return (pm == want_pm) && (cm == want_cm);
  endfunction
endpackage

// File: rtl/palette_bank_store.sv
module palette_bank_store
  import palette_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int NBANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [IDX_W-1:0] wr_idx,
  input  rgb_t             wr_data,
  input  logic             cpu_bank,
  input  logic [IDX_W-1:0] cpu_idx,
  output rgb_t             cpu_q,
  input  logic             pix_bank,
  input  logic [IDX_W-1:0] pix_idx,
  output rgb_t             pix_q
);
  rgb_t cpu_rd_q [NBANK];
  rgb_t pix_rd_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rgb_t mem [ENTRIES];
    wire  bank_we = wr_en && (wr_bank == 1'(b));

    always_ff @(posedge clk) begin
      if (bank_we) mem[wr_idx] <= wr_data;
    end

    assign cpu_rd_q[b] = mem[cpu_idx];
    assign pix_rd_q[b] = mem[pix_idx];
  end

  assign cpu_q = cpu_rd_q[cpu_bank];
  assign pix_q = pix_rd_q[pix_bank];

  // R3: the bank being written is never the bank feeding lookups
  p_wr_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_bank != pix_bank));
endmodule

// File: rtl/palette_swap_ctrl.sv
module palette_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic req_in,
  input  logic frame_start,
  output logic req,
  output logic live,
  output logic pending,
  output logic swap_now
);
  assign pending  = req ^ live;
  assign swap_now = frame_start && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      live <= 1'b0;
    end else begin
      if (ctrl_wr)  req  <= req_in;
      if (swap_now) live <= req;
    end
  end

  // R6: the live bank only moves on a frame-start cycle
  p_live_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(live));

  // R6: after a frame-start cycle the live flag equals the request of that cycle
  p_live_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (live == $past(req)));

  // R5: a control write loads the request bit
  p_req_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (req == $past(req_in)));
endmodule

// File: rtl/palette_cpu_port.sv
module palette_cpu_port
  import palette_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = IDX_W + 3,
  localparam int WA_W   = ADDR_W - 2,
  localparam logic [WA_W-1:0] CTRL_WA = WA_W'(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic              req,
  input  logic              live,
  input  rgb_t              entry_q,
  output logic              pal_wr,
  output logic [IDX_W-1:0]  pal_idx,
  output rgb_t              pal_wdata,
  output logic              ctrl_wr,
  output logic              ctrl_req
);
  logic [WA_W-1:0]   word_addr;
  logic              pal_hit;
  logic              ctrl_hit;
  logic [WORD_W-1:0] rd_next;
  logic              spare_unused;

  assign word_addr = cpu_addr[ADDR_W-1:2];
  assign pal_hit   = !word_addr[WA_W-1];
  assign ctrl_hit  = (word_addr == CTRL_WA);
  assign pal_idx   = word_addr[IDX_W-1:0];

  assign pal_wr    = cpu_wr && pal_hit;
  assign pal_wdata = bits_to_rgb(cpu_wdata[ENTRY_W-1:0]);
  assign ctrl_wr   = cpu_wr && ctrl_hit;
  assign ctrl_req  = cpu_wdata[0];

  assign spare_unused = ^{cpu_addr[1:0], cpu_wdata[WORD_W-1:ENTRY_W]};

  always_comb begin
    rd_next = '0;
    if (cpu_rd) begin
      if (pal_hit)       rd_next = rgb_to_word(entry_q);
      else if (ctrl_hit) rd_next = ctrl_word(live, req);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_rdata <= '0;
    else        cpu_rdata <= rd_next;
  end

  // R4: no read strobe, no read data
  p_rd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> (cpu_rdata == '0));

  // R2: the byte above the colour is never returned
  p_rd_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[WORD_W-1:ENTRY_W] == '0);

  // R5: the control word carries only two bits
  p_ctrl_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && ctrl_hit) |=> (cpu_rdata[WORD_W-1:2] == '0));

  // R10: an unmapped access touches neither palette nor control
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !pal_hit && !ctrl_hit) |-> !(pal_wr || ctrl_wr));
endmodule

// File: rtl/palette_pixel_path.sv
module palette_pixel_path
  import palette_pkg::*;
#(
  parameter logic [MODE_W-1:0] LUT_PIX_MODE = 3'd2,
  parameter logic [MODE_W-1:0] LUT_COL_MODE = 3'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [MODE_W-1:0] pix_mode,
  input  logic [MODE_W-1:0] col_mode,
  input  rgb_t              lut_q,
  output logic              rgb_valid,
  output rgb_t              rgb
);
  logic lut_sel;
  logic take;

  assign lut_sel = is_index_fmt(pix_mode, col_mode, LUT_PIX_MODE, LUT_COL_MODE);
  assign take    = pix_valid && lut_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb       <= '0;
    end else begin
      rgb_valid <= take;
      rgb       <= take ? lut_q : '0;
    end
  end

  // R7: an indexed pixel yields a colour one cycle later
  p_lut_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (rgb_valid && (rgb == $past(lut_q))));

  // R8: anything else leaves the output dark
  p_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (!rgb_valid && (rgb == '0)));
endmodule

// File: rtl/palette_dbuf.sv
module palette_dbuf
  import palette_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter logic [2:0] LUT_PIX_MODE = 3'd2,
  parameter logic [2:0] LUT_COL_MODE = 3'd0,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_index,
  input  logic [2:0]        pix_mode,
  input  logic [2:0]        col_mode,
  output logic              rgb_valid,
  output logic [23:0]       rgb_out
);
  logic             req, live, pending, swap_now;
  logic             pal_wr, ctrl_wr, ctrl_req;
  logic [IDX_W-1:0] pal_idx;
  rgb_t             pal_wdata, entry_q, lut_q, rgb;
  logic             shadow;

  assign shadow = ~live;

  palette_swap_ctrl u_swap (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .req_in(ctrl_req),
    .frame_start(frame_start), .req(req), .live(live),
    .pending(pending), .swap_now(swap_now)
  );

  palette_cpu_port #(.ENTRIES(ENTRIES)) u_cpu (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .req(req), .live(live), .entry_q(entry_q),
    .pal_wr(pal_wr), .pal_idx(pal_idx), .pal_wdata(pal_wdata),
    .ctrl_wr(ctrl_wr), .ctrl_req(ctrl_req)
  );

  palette_bank_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pal_wr), .wr_bank(shadow), .wr_idx(pal_idx), .wr_data(pal_wdata),
    .cpu_bank(shadow), .cpu_idx(pal_idx), .cpu_q(entry_q),
    .pix_bank(live), .pix_idx(pix_index), .pix_q(lut_q)
  );

  palette_pixel_path #(.LUT_PIX_MODE(LUT_PIX_MODE), .LUT_COL_MODE(LUT_COL_MODE)) u_pix (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_mode(pix_mode),
    .col_mode(col_mode), .lut_q(lut_q), .rgb_valid(rgb_valid), .rgb(rgb)
  );

  assign rgb_out = rgb;

  // R6 / R9: a frame pulse with nothing pending keeps the live bank
  p_no_pending_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !pending) |=> $stable(live));

  // R6: a swap empties the pending state
  p_swap_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_now && !ctrl_wr) |=> !pending);
endmodule

// File: tb/palette_dbuf_test.sv
module palette_dbuf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [10:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_index = '0;
  logic [2:0]  pix_mode = 3'd2, col_mode = 3'd0;
  logic        rgb_valid;
  logic [23:0] rgb_out;

  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "R1";

  palette_dbuf uut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .frame_start(frame_start), .pix_valid(pix_valid), .pix_index(pix_index),
    .pix_mode(pix_mode), .col_mode(col_mode),
    .rgb_valid(rgb_valid), .rgb_out(rgb_out)
  );

  always #10 clk = ~clk;

  // behavioural reference: two plain integer tables and two integer flags
  int bankm [2][256];
  int m_req, m_live, m_next_req, wa;
  bit m_lut;
  logic [31:0] exp_rdata;
  logic        exp_valid;
  logic [23:0] exp_rgb;
  string rd_tag, rgb_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_live = 0;
      exp_rdata = '0; exp_valid = 1'b0; exp_rgb = '0;
      rd_tag = "R1"; rgb_tag = "R1";
    end else begin
      wa = int'(cpu_addr) / 4;
      m_lut = (pix_mode == 3'd2) && (col_mode == 3'd0);
      exp_rdata = '0;
      rd_tag = "R4";
      if (cpu_rd) begin
        if (wa < 256) begin
          exp_rdata = 32'(bankm[1 - m_live][wa]);
          rd_tag = "R2 R4";
        end else if (wa == 256) begin
          exp_rdata = 32'(m_live * 2 + m_req);
          rd_tag = "R5";
        end else rd_tag = "R10";
      end
      exp_valid = pix_valid && m_lut;
      exp_rgb   = exp_valid ? 24'(bankm[m_live][pix_index]) : 24'h0;
      rgb_tag   = m_lut ? "R7" : "R8";
      m_next_req = m_req;
      if (cpu_wr) begin
        if (wa < 256) bankm[1 - m_live][wa] = int'(cpu_wdata & 32'h00FF_FFFF);
        else if (wa == 256) m_next_req = int'(cpu_wdata[0]);
      end
      if (frame_start) m_live = m_req;
      m_req = m_next_req;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", tag, what, act, exp);
    end
  endtask

  // every cycle after reset: compare with the model, one register stage behind
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(rgb_valid === exp_valid, {rgb_tag, " ", phase}, "rgb_valid",
            32'(rgb_valid), 32'(exp_valid));
      check(rgb_out === exp_rgb, {rgb_tag, " ", phase}, "rgb_out",
            32'(rgb_out), 32'(exp_rgb));
      check(cpu_rdata === exp_rdata, {rd_tag, " ", phase}, "cpu_rdata",
            cpu_rdata, exp_rdata);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act running exp done");
    finish_run();
  end

  function automatic logic [31:0] pat_a(input int n);
    return {8'hA5, 8'(n), 8'(255 - n), 8'(n ^ 8'h3C)};
  endfunction
  function automatic logic [31:0] pat_b(input int n);
    return {8'h7E, 8'(n * 3), 8'(n ^ 8'h55), 8'(n + 17)};
  endfunction

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic stream(input int count, input int step);
    for (int n = 0; n < count; n++) begin
      pix_valid = 1'b1; pix_index = 8'(n * step);
      @(negedge clk);
    end
    pix_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the outputs
    check(rgb_valid === 1'b0, "R1", "rgb_valid", 32'(rgb_valid), 0);
    check(rgb_out === 24'h0, "R1", "rgb_out", 32'(rgb_out), 0);
    check(cpu_rdata === 32'h0, "R1", "cpu_rdata", cpu_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1"; rd(11'h400);

    // R2 / R3: load the shadow bank (bank 1) with pattern A, top byte garbage
    phase = "R2 R3";
    for (int n = 0; n < 256; n++) wr(11'(4 * n), pat_a(n));
    phase = "R2 R4";
    for (int n = 0; n < 256; n += 15) rd(11'(4 * n));
    rd(11'h3FC);

    // R6: request pending until a frame pulse
    phase = "R6";
    wr(11'h400, 32'h1);
    rd(11'h400);
    repeat (5) @(negedge clk);
    rd(11'h400);
    frame();
    rd(11'h400);

    // R7: lookups now come from bank 1
    phase = "R7";
    stream(300, 7);

    // R3: rewrite the shadow bank (bank 0) with pattern B while lookups run
    phase = "R3";
    for (int n = 0; n < 256; n++) begin
      cpu_wr = 1'b1; cpu_addr = 11'(4 * n); cpu_wdata = pat_b(n);
      pix_valid = 1'b1; pix_index = 8'(255 - n);
      @(negedge clk);
    end
    cpu_wr = 1'b0; pix_valid = 1'b0;
    for (int n = 0; n < 256; n += 31) rd(11'(4 * n));

    // R8: other pixel formats and idle cycles stay dark
    phase = "R8";
    pix_mode = 3'd4; col_mode = 3'd0; stream(8, 3);
    pix_mode = 3'd2; col_mode = 3'd4; stream(8, 5);
    pix_mode = 3'd7; col_mode = 3'd5; stream(8, 9);
    pix_mode = 3'd2; col_mode = 3'd0;
    repeat (3) @(negedge clk);

    // R5: writing the status bit has no effect
    phase = "R5";
    wr(11'h400, 32'hFFFF_FFFF);
    rd(11'h400);
    wr(11'h400, 32'hFFFF_FFFF & ~32'h2);
    rd(11'h400);

    // R9: request toggled and restored before the frame pulse
    phase = "R9";
    wr(11'h400, 32'h0);
    rd(11'h400);
    wr(11'h400, 32'h1);
    frame();
    rd(11'h400);
    stream(40, 11);

    // R6: real swap back to bank 0, pixels around the pulse
    phase = "R6";
    wr(11'h400, 32'h0);
    stream(10, 13);
    pix_valid = 1'b1; pix_index = 8'd77; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; pix_index = 8'd77;
    @(negedge clk);
    pix_valid = 1'b0;
    rd(11'h400);
    stream(60, 5);

    // R10: unmapped offsets
    phase = "R10";
    wr(11'h404, 32'h00FF_FFFF);
    wr(11'h7FC, 32'h0000_0001);
    rd(11'h404);
    rd(11'h7FC);
    rd(11'h400);
    for (int n = 0; n < 256; n += 51) rd(11'(4 * n));
    frame();
    rd(11'h400);
    stream(20, 3);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule